// File: doc/BRIEF.md
# I2S Clock and Framing Generator

This block runs on the audio master clock. From it, the block derives a bit clock and a frame clock (word select), and it shifts a stereo pair of sample words onto one serial data line, most significant bit first. A small set of configuration inputs chooses the following:

- the clock divider ratio, in one of two encodings;
- the number of bit periods per frame;
- the output polarities;
- the delay of the data relative to the frame clock edge, in bit periods;
- the sample width, 16 or 32 bits.

With a skew of zero and no inversion, the framing is left-justified. With a skew of one and the frame clock inverted, the framing is standard I2S.

A source feeds sample pairs through a pending register pair, written whenever `sample_valid` is high. When the first bit of the left word is driven, the pending pair moves into the active pair and `req_o` pulses for one cycle, asking for the next pair. If the source writes nothing before the next frame, the same pair is sent again.

While the divider enable is low, every output is held static. Configuration may then be changed safely. When the enable rises, the frame starts cleanly from its first bit.

Top module: `i2s_frame_gen`

## Requirements
- R1: During reset, and in every cycle while `div_en` is low, the internal bit clock and frame clock sit at 0. So `bclk_o` equals `bclk_inv`, `lrclk_o` equals `lrclk_inv`, and `sdata_o` and `req_o` are 0. The state restarts so that the first falling bit clock edge after enable begins frame bit 0.
- R2: The bit clock half period is D clock cycles. D is `div_lin`+1 when `div_lin` is nonzero. Otherwise D is 2**`div_log2`, giving the only legacy ratios 1, 2, 4 and 8. The bit clock first rises D cycles after the enable goes high.
- R3: A frame lasts N = `frame_len_m1`+1 bit periods; 63 gives 64. The internal frame clock is high for bit positions below H = floor(N/2) and low for the rest. The frame clock and the data change only on falling edges of the internal bit clock.
- R4: `bclk_o` is the internal bit clock XOR `bclk_inv`. `lrclk_o` is the internal frame clock XOR `lrclk_inv`.
- R5: The data position is the frame bit position minus `skew`, modulo N, with `skew` from 0 to 3. Positions 0 to H-1 carry the left word, and positions H to N-1 carry the right word. Each word is sent MSB first. Bit k of a half is the word bit W-1-k when k < W, and 0 otherwise.
- R6: With `wide_sample`=1, W is 32 and the full inputs are used. With `wide_sample`=0, W is 16 and only bits [15:0] of the inputs are sent, with bit 15 first.
- R7: `req_o` is high for exactly one cycle, in the cycle where `sdata_o` first shows the left word (data position 0). The active pair is loaded from the pending pair at that point. `sample_valid` writes the pending pair on any cycle. An unwritten pending pair repeats the previous samples.
- R8: With `skew`=1 and `lrclk_inv`=1, `lrclk_o` is low while the left word's MSB is on the line (I2S framing).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| div_en | input | 1 | Divider enable; low holds outputs static |
| div_log2 | input | 2 | Legacy divider, log2 of half-period ratio |
| div_lin | input | 6 | Linear divider, ratio minus one; nonzero overrides |
| frame_len_m1 | input | 12 | Bit periods per frame minus one |
| bclk_inv | input | 1 | Invert bit clock output |
| lrclk_inv | input | 1 | Invert frame clock output |
| skew | input | 2 | Data delay after frame edge, in bit periods |
| wide_sample | input | 1 | 1: 32-bit samples, 0: 16-bit samples |
| left_in | input | 32 | Left sample for the pending pair |
| right_in | input | 32 | Right sample for the pending pair |
| sample_valid | input | 1 | Write left_in/right_in into the pending pair |
| bclk_o | output | 1 | Bit clock |
| lrclk_o | output | 1 | Frame clock (word select) |
| sdata_o | output | 1 | Serial data, MSB first |
| req_o | output | 1 | One-cycle request for the next sample pair |

## Verification
A divider count that is off by one shows at `bclk_o` within the first half period after enable. It then keeps shifting every later edge. A wrong bit position or skew offset shows on `sdata_o` at the first falling edge where the expected data bit differs. It also moves `req_o` by whole bit periods within the first frame. A swap between the pending and active pairs, or a missed load, only shows one frame later, when a stale word is serialized. For that reason the source alternates between feeding and skipping across several frames.

// File: rtl/i2s_fg_pkg.sv
package i2s_fg_pkg;

    localparam int SAMPLE_W = 32;
    localparam int LOG_W    = 2;
    localparam int LIN_W    = 6;
    localparam int FRAME_W  = 12;
    localparam int SKEW_W   = 2;
    localparam int LEG_MAXW = (1 << LOG_W) - 1;
    localparam int CNT_W    = (LIN_W > LEG_MAXW) ? LIN_W : LEG_MAXW;

    typedef logic [FRAME_W:0] pos_t;

    typedef struct packed {
        logic [SAMPLE_W-1:0] left;
        logic [SAMPLE_W-1:0] right;
    } pair_t;

    typedef struct packed {
        logic                en;
        logic [LOG_W-1:0]    log2_div;
        logic [LIN_W-1:0]    lin_div;
        logic [FRAME_W-1:0]  frame_m1;
        logic                bclk_inv;
        logic                lr_inv;
        logic [SKEW_W-1:0]   skew;
        logic                wide;
    } cfg_t;

    // Half-period length minus one, linear code wins when nonzero
    function automatic logic [CNT_W-1:0] half_m1(logic [LOG_W-1:0] lg,
                                                 logic [LIN_W-1:0] ln);
        logic [CNT_W-1:0] pw;
        pw = '0;
        pw[lg] = 1'b1;
        if (ln != '0) return CNT_W'(ln);
        return pw - 1'b1;
    endfunction

    // Serial bit for a data position inside the frame
    function automatic logic pick_bit(pair_t p, pos_t dpos, pos_t half,
                                      logic wide, int narrow_w);
        pos_t                k;
        logic [SAMPLE_W-1:0] word;
        int                  w;
        w = wide ? SAMPLE_W : narrow_w;
        if (dpos >= half) begin
            k    = dpos - half;
            word = p.right;
        end else begin
            k    = dpos;
            word = p.left;
        end
        if (int'(k) < w) return word[w - 1 - int'(k)];
        return 1'b0;
    endfunction

endpackage

// File: rtl/i2s_fg_div.sv
module i2s_fg_div
    import i2s_fg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [LOG_W-1:0] log2_div,
    input  logic [LIN_W-1:0] lin_div,
    output logic             bclk_raw,
    output logic             fall
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim;
    logic             wrap;

    assign lim  = half_m1(log2_div, lin_div);
    assign wrap = en && (cnt_q >= lim);
    assign fall = wrap && bclk_raw;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q    <= '0;
            bclk_raw <= 1'b0;
        end else if (wrap) begin
            cnt_q    <= '0;
            bclk_raw <= ~bclk_raw;
        end else begin
            cnt_q    <= cnt_q + 1'b1;
        end
    end

    // R1: bit clock parked low after any disabled cycle
    a_r1_idle_low: assert property (@(posedge clk) disable iff (rst)
        !en |=> !bclk_raw);

endmodule

// File: rtl/i2s_fg_framer.sv
module i2s_fg_framer
    import i2s_fg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic               fall,
    input  logic [FRAME_W-1:0] frame_m1,
    input  logic [SKEW_W-1:0]  skew,
    output logic               lr_raw,
    output logic               adv,
    output pos_t               dpos,
    output pos_t               half
);
    logic [FRAME_W-1:0] bit_q;
    logic [FRAME_W-1:0] nxt;
    pos_t               len;
    pos_t               nxt_w;
    pos_t               skw;

    assign len   = {1'b0, frame_m1} + 1'b1;
    assign half  = len >> 1;
    assign nxt   = (bit_q >= frame_m1) ? '0 : bit_q + 1'b1;
    assign nxt_w = {1'b0, nxt};
    assign skw   = pos_t'(skew);
    assign dpos  = (nxt_w >= skw) ? nxt_w - skw : nxt_w + len - skw;
    assign adv   = en && fall;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            bit_q  <= frame_m1;
            lr_raw <= 1'b0;
        end else if (fall) begin
            bit_q  <= nxt;
            lr_raw <= (nxt_w < half);
        end
    end

    // R3: frame clock only moves on a falling bit clock edge
    a_r3_lr_on_fall: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && !$stable(lr_raw)) |-> $past(fall));

endmodule

// File: rtl/i2s_fg_shifter.sv
module i2s_fg_shifter
    import i2s_fg_pkg::*;
#(
    parameter int NARROW_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic                adv,
    input  pos_t                dpos,
    input  pos_t                half,
    input  logic                wide,
    input  logic                load_en,
    input  pair_t               load_pair,
    output logic                sd,
    output logic                req
);
    pair_t pend_q;
    pair_t act_q;
    pair_t src;
    logic  start;

    assign start = (dpos == '0);
    assign src   = start ? pend_q : act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            act_q  <= '0;
            sd     <= 1'b0;
            req    <= 1'b0;
        end else begin
            if (load_en) pend_q <= load_pair;
            if (!en) begin
                sd  <= 1'b0;
                req <= 1'b0;
            end else begin
                req <= adv && start;
                if (adv) begin
                    if (start) act_q <= pend_q;
                    sd <= pick_bit(src, dpos, half, wide, NARROW_W);
                end
            end
        end
    end

    // R7: request lasts a single cycle
    a_r7_req_single: assert property (@(posedge clk) disable iff (rst)
        req |=> !req);
    // R7: request only follows a bit advance
    a_r7_req_on_adv: assert property (@(posedge clk) disable iff (rst)
        req |-> $past(adv));
    // R5: data line only moves on a bit advance while running
    a_r5_sd_on_adv: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && !$stable(sd)) |-> $past(adv));

endmodule

// File: rtl/i2s_frame_gen.sv
module i2s_frame_gen
    import i2s_fg_pkg::*;
#(
    parameter int NARROW_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                div_en,
    input  logic [LOG_W-1:0]    div_log2,
    input  logic [LIN_W-1:0]    div_lin,
    input  logic [FRAME_W-1:0]  frame_len_m1,
    input  logic                bclk_inv,
    input  logic                lrclk_inv,
    input  logic [SKEW_W-1:0]   skew,
    input  logic                wide_sample,
    input  logic [SAMPLE_W-1:0] left_in,
    input  logic [SAMPLE_W-1:0] right_in,
    input  logic                sample_valid,
    output logic                bclk_o,
    output logic                lrclk_o,
    output logic                sdata_o,
    output logic                req_o
);
    cfg_t  cfg;
    pair_t in_pair;
    logic  bclk_raw, fall, lr_raw, adv;
    pos_t  dpos, half;

    assign cfg = '{en: div_en, log2_div: div_log2, lin_div: div_lin,
                   frame_m1: frame_len_m1, bclk_inv: bclk_inv,
                   lr_inv: lrclk_inv, skew: skew, wide: wide_sample};
    assign in_pair = '{left: left_in, right: right_in};

    i2s_fg_div u_div (
        .clk(clk), .rst(rst), .en(cfg.en),
        .log2_div(cfg.log2_div), .lin_div(cfg.lin_div),
        .bclk_raw(bclk_raw), .fall(fall)
    );

    i2s_fg_framer u_framer (
        .clk(clk), .rst(rst), .en(cfg.en), .fall(fall),
        .frame_m1(cfg.frame_m1), .skew(cfg.skew),
        .lr_raw(lr_raw), .adv(adv), .dpos(dpos), .half(half)
    );

    i2s_fg_shifter #(.NARROW_W(NARROW_W)) u_shift (
        .clk(clk), .rst(rst), .en(cfg.en), .adv(adv),
        .dpos(dpos), .half(half), .wide(cfg.wide),
        .load_en(sample_valid), .load_pair(in_pair),
        .sd(sdata_o), .req(req_o)
    );

    assign bclk_o  = bclk_raw ^ cfg.bclk_inv;
    assign lrclk_o = lr_raw ^ cfg.lr_inv;

    // R1: while disabled the serial outputs stay quiet
    a_r1_quiet: assert property (@(posedge clk) disable iff (rst)
        !div_en |=> (!sdata_o && !req_o));

endmodule

// File: tb/i2s_frame_gen_bench.sv
module i2s_frame_gen_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        div_en = 1'b0;
    logic [1:0]  div_log2 = 2'd0;
    logic [5:0]  div_lin = 6'd0;
    logic [11:0] frame_len_m1 = 12'd63;
    logic        bclk_inv = 1'b0;
    logic        lrclk_inv = 1'b0;
    logic [1:0]  skew = 2'd0;
    logic        wide_sample = 1'b1;
    logic [31:0] left_in = '0;
    logic [31:0] right_in = '0;
    logic        sample_valid = 1'b0;
    logic        bclk_o, lrclk_o, sdata_o, req_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    logic [31:0] seed = 32'h1ace_b00c;

    always #4 clk = ~clk;

    i2s_frame_gen u_i2s_frame_gen (
        .clk(clk), .rst(rst), .div_en(div_en), .div_log2(div_log2),
        .div_lin(div_lin), .frame_len_m1(frame_len_m1),
        .bclk_inv(bclk_inv), .lrclk_inv(lrclk_inv), .skew(skew),
        .wide_sample(wide_sample), .left_in(left_in), .right_in(right_in),
        .sample_valid(sample_valid), .bclk_o(bclk_o), .lrclk_o(lrclk_o),
        .sdata_o(sdata_o), .req_o(req_o)
    );

    // Behavioural reference
    int          m_cnt, m_bit;
    bit          m_bclk, m_lr, m_sd, m_req;
    logic [31:0] m_pl, m_pr, m_al, m_ar;

    function automatic bit ref_bit(logic [31:0] l, logic [31:0] r,
                                   int dp, int h, bit wide);
        int w = wide ? 32 : 16;
        int k = (dp >= h) ? dp - h : dp;
        logic [31:0] word = (dp >= h) ? r : l;
        if (k < w) return word[w - 1 - k];
        return 1'b0;
    endfunction

    always @(posedge clk) begin
        logic [31:0] opl, opr;
        int r, n, h, nb, dp;
        bit fall;
        opl = m_pl; opr = m_pr;
        if (rst) begin
            m_cnt = 0; m_bclk = 0; m_bit = frame_len_m1; m_lr = 0;
            m_sd = 0; m_req = 0; m_pl = 0; m_pr = 0; m_al = 0; m_ar = 0;
        end else begin
            if (sample_valid) begin m_pl = left_in; m_pr = right_in; end
            if (!div_en) begin
                m_cnt = 0; m_bclk = 0; m_bit = frame_len_m1; m_lr = 0;
                m_sd = 0; m_req = 0;
            end else begin
                r = (div_lin != 0) ? int'(div_lin) + 1 : (1 << div_log2);
                fall = 0;
                if (m_cnt >= r - 1) begin
                    m_cnt = 0; fall = m_bclk; m_bclk = !m_bclk;
                end else m_cnt++;
                m_req = 0;
                if (fall) begin
                    n  = int'(frame_len_m1) + 1;
                    h  = n / 2;
                    nb = (m_bit >= int'(frame_len_m1)) ? 0 : m_bit + 1;
                    m_bit = nb;
                    m_lr  = (nb < h);
                    dp = (nb - int'(skew) + n) % n;
                    if (dp == 0) begin m_al = opl; m_ar = opr; m_req = 1; end
                    m_sd = ref_bit(m_al, m_ar, dp, h, wide_sample);
                end
            end
        end
    end

    task automatic compare();
        bit eb, el;
        eb = m_bclk ^ bclk_inv;
        el = m_lr ^ lrclk_inv;
        n_chk++;
        if (bclk_o !== eb || lrclk_o !== el || sdata_o !== m_sd || req_o !== m_req)
            n_bad++;
        if (bclk_o !== eb)
            $display("FAIL R2 R4 bclk_o actual %b expected %b at %0t", bclk_o, eb, $time);
        if (lrclk_o !== el)
            $display("FAIL R3 R4 lrclk_o actual %b expected %b at %0t", lrclk_o, el, $time);
        if (sdata_o !== m_sd)
            $display("FAIL R5 R6 sdata_o actual %b expected %b at %0t", sdata_o, m_sd, $time);
        if (req_o !== m_req)
            $display("FAIL R7 req_o actual %b expected %b at %0t", req_o, m_req, $time);
    endtask

    task automatic check(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Run n cycles; feed mode 0 none, 1 every request, 2 every other request
    task automatic run(int n, int feed, bit i2s_chk);
        int reqs = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare();
            if (i2s_chk && req_o)   // R8: left MSB goes out while frame clock low
                check(lrclk_o == 1'b0, "R8 lrclk_o at left start", lrclk_o, 0);
            sample_valid = 1'b0;
            if (req_o) begin
                reqs++;
                if (feed == 1 || (feed == 2 && reqs[0])) begin
                    seed = seed * 32'd1664525 + 32'd1013904223;
                    left_in = seed;
                    seed = seed * 32'd1664525 + 32'd1013904223;
                    right_in = seed;
                    sample_valid = 1'b1;
                end
            end
        end
    endtask

    task automatic reconfigure(logic [1:0] lg, logic [5:0] ln, logic [11:0] fl,
                               bit bi, bit li, logic [1:0] sk, bit wd);
        div_en = 1'b0;
        run(3, 0, 0);
        div_log2 = lg; div_lin = ln; frame_len_m1 = fl;
        bclk_inv = bi; lrclk_inv = li; skew = sk; wide_sample = wd;
        run(2, 0, 0);
        div_en = 1'b1;
    endtask

    initial begin
        bit b0;
        repeat (4) @(negedge clk);
        // R1: reset state at the ports
        check(bclk_o == 0 && lrclk_o == 0 && sdata_o == 0 && req_o == 0,
              "R1 outputs in reset", {bclk_o, lrclk_o, sdata_o, req_o}, 0);
        rst = 1'b0;
        left_in = 32'h8000_0001; right_in = 32'hF0F0_A5A5; sample_valid = 1'b1;
        @(negedge clk);
        sample_valid = 1'b0;
        // Left-justified, legacy ratio 2, 32-bit
        reconfigure(2'd1, 6'd0, 12'd63, 0, 0, 2'd0, 1);
        run(900, 1, 0);
        // I2S framing, linear ratio 3, 16-bit, 32-bit frame
        reconfigure(2'd2, 6'd2, 12'd31, 0, 1, 2'd1, 0);
        run(900, 2, 1);
        // Linear overrides legacy 8, inverted bclk, skew 3
        reconfigure(2'd3, 6'd1, 12'd63, 1, 0, 2'd3, 1);
        run(900, 1, 0);
        // Odd frame length, legacy ratio 4, skew 2, repeated samples
        reconfigure(2'd2, 6'd0, 12'd40, 0, 1, 2'd2, 1);
        run(1400, 0, 0);
        // Fastest legacy ratio 1
        reconfigure(2'd0, 6'd0, 12'd15, 1, 1, 2'd0, 0);
        run(300, 1, 0);
        // R1: disable mid-frame, outputs static at polarity levels
        div_en = 1'b0;
        run(2, 0, 0);
        b0 = bclk_o;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            compare();
            check(bclk_o == b0 && bclk_o == bclk_inv && lrclk_o == lrclk_inv &&
                  sdata_o == 0 && req_o == 0, "R1 static while disabled",
                  {bclk_o, lrclk_o, sdata_o, req_o}, {bclk_inv, lrclk_inv, 2'b00});
        end
        div_en = 1'b1;
        run(200, 1, 0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired, actual running expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule